// File: doc/BRIEF.md
# Parallel Handshake Group Controller

This block runs the handshake of one 16-bit parallel port group. It watches a request line from an external device and drives an acknowledge line back. A data-ready flag tells the host when the port may be written (output direction) or read (input direction). The request is resynchronised and can be interpreted in one of three ways: as a level, as a pulse acting on its leading edge, or as a pulse acting on its trailing edge. Once the host has touched the port data, a programmable settling delay runs before acknowledge is driven. In the pulse modes the same delay also sets the acknowledge width, and an optional stretch setting lengthens that width further.

The port data can be single- or double-buffered. A double-buffered output holds host writes in a staging register and only moves them to the pins when the device's request arrives. A double-buffered input freezes the pin values at the request so the host reads a stable snapshot. A DMA request and an interrupt request follow the data-ready flag, each under its own enable. A local reset parks the group. The write handshake does not start again until the direction bit has been cleared and then set.

Top module: `hs_group_ctrl`

## Requirements
- R1: The request mode is chosen by two bits. With `cfg_pulse`=0 the mode is level. With `cfg_pulse`=1 and `cfg_trail`=0 it is leading-edge. With both set it is trailing-edge. In level and leading-edge modes, data-ready goes high on the third rising clock edge after the request pin becomes active.
- R2: In input direction (`cfg_write`=0), data-ready is set by an accepted request. It then stays set until a host read strobe, and it is low from the clock edge that samples that strobe.
- R3: In output direction, data-ready goes high on the first clock edge at which `cfg_port_en` and `cfg_write` are both high (when no re-arm is pending). A host write strobe clears it on the edge that samples the strobe.
- R4: After the strobe that clears data-ready, acknowledge stays inactive for exactly `cfg_dly_sel` clock cycles and then becomes active.
- R5: In the pulse modes without stretch, acknowledge is active for `cfg_dly_sel` cycles, or for one cycle when `cfg_dly_sel` is 0.
- R6: With `cfg_dly_stretch`=1 in a pulse mode, the acknowledge width grows by a further `cfg_dly_sel` cycles.
- R7: In level mode, acknowledge stays active while the request is held. It drops on the third clock edge after the request pin goes inactive, and no new data-ready follows until the request is asserted again.
- R8: When `cfg_inv_req`=1 the request is active low. When `cfg_inv_ack`=1 `ack_pin` is active low, so it idles high. When these bits are clear, both lines are active high.
- R9: `lreset` clears data-ready and acknowledge on the next edge and disarms the group. The output handshake is not re-armed until `cfg_write` has been low for at least one edge and is set again.
- R10: With `cfg_dblbuf`=0, a host write appears on `pin_out` on the edge that samples it. With `cfg_dblbuf`=1, `pin_out` keeps its old value until the next accepted request, and changes on the same edge that sets data-ready.
- R11: In input direction with `cfg_dblbuf`=1, `host_rdata` returns the `pin_in` value captured on the edge where the request was accepted. With `cfg_dblbuf`=0, it returns the live `pin_in`.
- R12: `dma_req` is high exactly when data-ready and `cfg_dma_en` are both high. `irq` is high exactly when data-ready and `cfg_irq_en` are both high.
- R13: In trailing-edge mode, asserting the request does not set data-ready. Data-ready goes high on the third edge after the request pin returns to inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one settling-delay step |
| rst_n | input | 1 | Synchronous active-low reset |
| lreset | input | 1 | Local group reset, one-cycle pulse |
| cfg_port_en | input | 1 | Port enable for handshaking |
| cfg_write | input | 1 | Direction: 1 output, 0 input |
| cfg_pulse | input | 1 | 1 selects a pulse mode, 0 level mode |
| cfg_trail | input | 1 | In pulse mode, 1 selects trailing edge |
| cfg_dly_sel | input | 3 | Settling delay in clock cycles |
| cfg_dly_stretch | input | 1 | Adds the delay again after the ACK leading edge |
| cfg_inv_req | input | 1 | Request active low when set |
| cfg_inv_ack | input | 1 | Acknowledge active low when set |
| cfg_dblbuf | input | 1 | Double-buffer the port data |
| cfg_dma_en | input | 1 | DMA request enable |
| cfg_irq_en | input | 1 | Interrupt request enable |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data |
| req_pin | input | 1 | Request from external device (asynchronous) |
| ack_pin | output | 1 | Acknowledge to external device |
| pin_in | input | 16 | Port pins, input direction |
| pin_out | output | 16 | Port pins, output direction |
| drdy | output | 1 | Data-ready flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the settling-delay boundary at zero, where a counter that is off by one would give a zero-width acknowledge or a full extra cycle. It also goes after the stretch setting, which a wrong design would ignore or apply twice. It checks trailing-edge mode while the request is held: a design that treated every edge alike would raise data-ready too early. Level mode with the request held long is checked for an acknowledge dropped before release. It also probes the output buffer before the request arrives (a leaky buffer shows the new word early), the frozen input snapshot after the pins change, and re-arming after a local reset, where a careless design would re-arm on its own.

// File: rtl/hsg_pkg.sv
// Package: shared types for the handshake group controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hsg_pkg;

    // Interpretation of the request line
    typedef enum logic [1:0] {
        MODE_LEVEL = 2'd0,
        MODE_LEAD  = 2'd1,
        MODE_TRAIL = 2'd2
    } hs_mode_e;

    // Handshake sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_REQ = 3'd1,
        ST_READY    = 3'd2,
        ST_SETTLE   = 3'd3,
        ST_ACK      = 3'd4
    } hs_state_e;

    // Map the two mode bits onto a request interpretation
    function automatic hs_mode_e decode_mode(input logic pulse, input logic trail);
        if (!pulse)     return MODE_LEVEL;
        else if (trail) return MODE_TRAIL;
        else            return MODE_LEAD;
    endfunction

endpackage

// File: rtl/hsg_req_front.sv
// Module: hsg_req_front
// Brings the asynchronous request into the clock domain through a
// flip-flop chain, applies the polarity, and reports the event that the
// selected mode treats as a request.
// Assumes: SYNC_STAGES >= 2; polarity only changes while the group is idle.
module hsg_req_front
    import hsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_pin,
    input  logic     inv_req,
    input  hs_mode_e mode,
    output logic     req_lvl,
    output logic     req_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    // Synchroniser chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], req_pin ^ inv_req};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign req_lvl = sync_q[SYNC_STAGES-1];
    assign rise    = req_lvl & ~prev_q;
    assign fall    = ~req_lvl & prev_q;

    // Select the event the active mode responds to
    always_comb begin
        unique case (mode)
            MODE_LEVEL: req_evt = req_lvl;
            MODE_LEAD:  req_evt = rise;
            MODE_TRAIL: req_evt = fall;
            default:    req_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/hsg_seq.sv
// Module: hsg_seq
// Handshake sequencer: arming, data-ready, settling delay and acknowledge
// timing. One counter serves both the settle phase and the pulse width.
// Assumes: strobes are single-cycle; config is static while a transfer runs.
module hsg_seq
    import hsg_pkg::*;
#(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lreset,
    input  logic             en,
    input  logic             write,
    input  hs_mode_e         mode,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             stretch,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic             req_lvl,
    input  logic             req_evt,
    output logic             drdy,
    output logic             ack_act,
    output logic             take_evt
);

    localparam int CNT_W = DLY_W + 1;

    hs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_q;
    logic             rearm_q;
    logic             access;
    logic             disarm;
    logic [CNT_W-1:0] sel_ext;
    logic [CNT_W-1:0] ack_width;

    assign sel_ext   = {1'b0, dly_sel};
    assign ack_width = ((dly_sel == '0) ? CNT_W'(1) : sel_ext)
                     + (stretch ? sel_ext : '0);
    assign access    = write ? host_wr : host_rd;
    assign disarm    = lreset || !en || ((state_q != ST_IDLE) && (write != dir_q));
    assign take_evt  = (state_q == ST_WAIT_REQ) && req_evt && !disarm;

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (disarm) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (write && !rearm_q) state_d = ST_READY;
                    else if (!write)       state_d = ST_WAIT_REQ;
                end
                ST_WAIT_REQ: begin
                    if (req_evt) state_d = ST_READY;
                end
                ST_READY: begin
                    if (access) begin
                        if (dly_sel == '0) begin
                            state_d = ST_ACK;
                            cnt_d   = ack_width;
                        end else begin
                            state_d = ST_SETTLE;
                            cnt_d   = sel_ext;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        state_d = ST_ACK;
                        cnt_d   = ack_width;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_ACK: begin
                    if (mode == MODE_LEVEL) begin
                        if (!req_lvl) state_d = ST_WAIT_REQ;
                    end else if (cnt_q <= CNT_W'(1)) begin
                        state_d = ST_WAIT_REQ;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, counter and armed-direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE) dir_q <= write;
        end
    end

    // Pending re-arm after a local reset, released by a low direction bit
    always_ff @(posedge clk) begin
        if (!rst_n)      rearm_q <= 1'b0;
        else if (lreset) rearm_q <= 1'b1;
        else if (!write) rearm_q <= 1'b0;
    end

    assign drdy    = (state_q == ST_READY);
    assign ack_act = (state_q == ST_ACK);

endmodule

// File: rtl/hsg_datapath.sv
// Module: hsg_datapath
// Port data registers: output staging and pin registers, and the input
// snapshot taken when a request is accepted.
// Assumes: take_evt is a single-cycle pulse from the sequencer.
module hsg_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write,
    input  logic              dblbuf,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              take_evt,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] host_rdata
);

    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] in_q;

    // Host writes fill the staging register
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q <= '0;
        else if (host_wr) stage_q <= host_wdata;
    end

    // Pin register: direct write, or transfer from staging on a request
    always_ff @(posedge clk) begin
        if (!rst_n)                          out_q <= '0;
        else if (host_wr && !dblbuf)         out_q <= host_wdata;
        else if (take_evt && write && dblbuf) out_q <= stage_q;
    end

    // Input snapshot on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                in_q <= '0;
        else if (take_evt && !write) in_q <= pin_in;
    end

    assign pin_out    = out_q;
    assign host_rdata = write ? out_q : (dblbuf ? in_q : pin_in);

endmodule

// File: rtl/hs_group_ctrl.sv
// Module: hs_group_ctrl (top)
// One parallel-port handshake group: request front end, sequencer and
// data registers, plus DMA and interrupt requests taken from data-ready.
// Assumes: clk period is the settling-delay step; config changes only
// while the group is idle or ready.
module hs_group_ctrl
    import hsg_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DLY_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreset,
    input  logic              cfg_port_en,
    input  logic              cfg_write,
    input  logic              cfg_pulse,
    input  logic              cfg_trail,
    input  logic [DLY_W-1:0]  cfg_dly_sel,
    input  logic              cfg_dly_stretch,
    input  logic              cfg_inv_req,
    input  logic              cfg_inv_ack,
    input  logic              cfg_dblbuf,
    input  logic              cfg_dma_en,
    input  logic              cfg_irq_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              req_pin,
    output logic              ack_pin,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              drdy,
    output logic              dma_req,
    output logic              irq
);

    hs_mode_e mode;
    logic     req_lvl;
    logic     req_evt;
    logic     ack_act;
    logic     take_evt;

    assign mode = decode_mode(cfg_pulse, cfg_trail);

    hsg_req_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_pin (req_pin),
        .inv_req (cfg_inv_req),
        .mode    (mode),
        .req_lvl (req_lvl),
        .req_evt (req_evt)
    );

    hsg_seq #(.DLY_W(DLY_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lreset   (lreset),
        .en       (cfg_port_en),
        .write    (cfg_write),
        .mode     (mode),
        .dly_sel  (cfg_dly_sel),
        .stretch  (cfg_dly_stretch),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .req_lvl  (req_lvl),
        .req_evt  (req_evt),
        .drdy     (drdy),
        .ack_act  (ack_act),
        .take_evt (take_evt)
    );

    hsg_datapath #(.DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .write      (cfg_write),
        .dblbuf     (cfg_dblbuf),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .take_evt   (take_evt),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .host_rdata (host_rdata)
    );

    assign ack_pin = ack_act ^ cfg_inv_ack;
    assign dma_req = drdy & cfg_dma_en;
    assign irq     = drdy & cfg_irq_en;

endmodule

// File: rtl/hsg_chk.sv
// Module: hsg_chk
// Protocol checks on the group's ports, attached to hs_group_ctrl by bind.
// Assumes: single clock, synchronous active-low reset.
module hsg_chk #(
    parameter int DLY_W = 3
) (
    input logic clk,
    input logic rst_n,
    input logic lreset,
    input logic cfg_port_en,
    input logic cfg_write,
    input logic cfg_pulse,
    input logic cfg_inv_ack,
    input logic host_wr,
    input logic host_rd,
    input logic drdy,
    input logic ack_pin
);

    localparam int MAXW  = 2 * ((1 << DLY_W) - 1);
    localparam int RUN_W = DLY_W + 2;

    logic             act;
    logic [RUN_W-1:0] run_q;

    assign act = ack_pin ^ cfg_inv_ack;

    // Length of the current acknowledge pulse in pulse modes
    always_ff @(posedge clk) begin
        if (!rst_n)                     run_q <= '0;
        else if (act && cfg_pulse)      run_q <= (run_q == RUN_W'(MAXW)) ? run_q : run_q + RUN_W'(1);
        else                            run_q <= '0;
    end

    // R2
    drdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !host_wr && !host_rd && cfg_port_en && !lreset && $stable(cfg_write) |=> drdy);

    // R3
    drdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && (cfg_write ? host_wr : host_rd) && cfg_port_en && !lreset |=> !drdy);

    // R4
    ready_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drdy && act));

    // R5
    ack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && cfg_pulse |-> (run_q < RUN_W'(MAXW)));

    // R9
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lreset || !cfg_port_en |=> !drdy && !act);

endmodule

bind hs_group_ctrl hsg_chk #(.DLY_W(DLY_W)) u_hsg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lreset      (lreset),
    .cfg_port_en (cfg_port_en),
    .cfg_write   (cfg_write),
    .cfg_pulse   (cfg_pulse),
    .cfg_inv_ack (cfg_inv_ack),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .drdy        (drdy),
    .ack_pin     (ack_pin)
);

// File: tb/test_hs_group_ctrl.sv
// Bench for hs_group_ctrl: seeded random output-direction transfers across
// delays, stretch, modes and buffering, plus directed input, polarity and
// local-reset cases. Inputs change on falling edges; outputs are sampled there.
module test_hs_group_ctrl;

    logic        clk = 1'b0;
    logic        rst_n, lreset, cfg_port_en, cfg_write, cfg_pulse, cfg_trail;
    logic [2:0]  cfg_dly_sel;
    logic        cfg_dly_stretch, cfg_inv_req, cfg_inv_ack, cfg_dblbuf;
    logic        cfg_dma_en, cfg_irq_en, host_wr, host_rd, req_pin;
    logic [15:0] host_wdata, host_rdata, pin_in, pin_out;
    logic        ack_pin, drdy, dma_req, irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    hs_group_ctrl i_hs_group_ctrl (
        .clk(clk), .rst_n(rst_n), .lreset(lreset), .cfg_port_en(cfg_port_en),
        .cfg_write(cfg_write), .cfg_pulse(cfg_pulse), .cfg_trail(cfg_trail),
        .cfg_dly_sel(cfg_dly_sel), .cfg_dly_stretch(cfg_dly_stretch),
        .cfg_inv_req(cfg_inv_req), .cfg_inv_ack(cfg_inv_ack), .cfg_dblbuf(cfg_dblbuf),
        .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .req_pin(req_pin), .ack_pin(ack_pin), .pin_in(pin_in), .pin_out(pin_out),
        .drdy(drdy), .dma_req(dma_req), .irq(irq)
    );

    function automatic logic ack_on();
        return ack_pin ^ cfg_inv_ack;
    endfunction

    function automatic int exp_width(input int sel, input bit str);
        return ((sel == 0) ? 1 : sel) + (str ? sel : 0);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_wr(input logic [15:0] d);
        host_wdata = d;
        host_wr    = 1'b1;
        tick();
        host_wr    = 1'b0;
    endtask

    task automatic strobe_rd();
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic measure(output int settle, output int width);
        settle = 0;
        width  = 0;
        while (!ack_on() && settle < 40) begin settle++; tick(); end
        while (ack_on() && width < 40)   begin width++;  tick(); end
    endtask

    task automatic wait_drdy(output int cyc);
        cyc = 0;
        while (!drdy && cyc < 20) begin tick(); cyc++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int s, w, c, sel;
        bit str, trl, dbl, den, ien;
        logic [15:0] data, exp_pin;
        s = $urandom(32'h5eed);
        rst_n = 0; lreset = 0; cfg_port_en = 0; cfg_write = 0; cfg_pulse = 0;
        cfg_trail = 0; cfg_dly_sel = 0; cfg_dly_stretch = 0; cfg_inv_req = 0;
        cfg_inv_ack = 0; cfg_dblbuf = 0; cfg_dma_en = 0; cfg_irq_en = 0;
        host_wr = 0; host_rd = 0; host_wdata = 0; req_pin = 0; pin_in = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R9", "reset drdy", drdy, 0);
        check("R9", "reset ack_pin", ack_pin, 0);
        check("R10", "reset pin_out", pin_out, 0);
        check("R12", "reset dma/irq", {dma_req, irq}, 0);

        // Output direction, pulse modes, random settings
        cfg_write = 1; cfg_pulse = 1; cfg_port_en = 1;
        tick();
        check("R3", "drdy one edge after arming", drdy, 1);
        exp_pin = 16'h0;
        for (int it = 0; it < 24; it++) begin
            sel = $urandom % 8; str = 1'($urandom); trl = 1'($urandom);
            dbl = 1'($urandom); den = 1'($urandom); ien = 1'($urandom);
            data = 16'($urandom);
            if (it == 0) sel = 0;
            if (it == 1) sel = 7;
            cfg_dly_sel = 3'(sel); cfg_dly_stretch = str; cfg_trail = trl;
            cfg_dblbuf = dbl; cfg_dma_en = den; cfg_irq_en = ien;
            tick();
            check("R12", "dma_req while ready", dma_req, int'(den));
            check("R12", "irq while ready", irq, int'(ien));
            strobe_wr(data);
            check("R3", "drdy cleared by write", drdy, 0);
            check("R12", "dma_req after write", dma_req, 0);
            if (!dbl) exp_pin = data;
            check("R10", "pin_out after write", pin_out, exp_pin);
            measure(s, w);
            check("R4", "settle cycles", s, sel);
            check(str ? "R6" : "R5", "ack width", w, exp_width(sel, str));
            check("R10", "pin_out before request", pin_out, exp_pin);
            req_pin = 1;
            if (!trl) begin
                wait_drdy(c);
                check("R1", "leading-edge drdy latency", c, 3);
                req_pin = 0;
            end else begin
                repeat (4) tick();
                check("R13", "no drdy while request held", drdy, 0);
                req_pin = 0;
                wait_drdy(c);
                check("R13", "trailing-edge drdy latency", c, 3);
            end
            if (dbl) exp_pin = data;
            check("R10", "pin_out after request", pin_out, exp_pin);
        end

        // Input direction, level mode, snapshot buffer
        cfg_port_en = 0; tick();
        cfg_write = 0; cfg_pulse = 0; cfg_trail = 0; cfg_dblbuf = 1;
        cfg_dly_sel = 3; cfg_dly_stretch = 0; cfg_dma_en = 1;
        repeat (3) tick();
        cfg_port_en = 1; tick();
        check("R2", "no drdy before request", drdy, 0);
        pin_in = 16'hA5C3; req_pin = 1;
        wait_drdy(c);
        check("R1", "level drdy latency", c, 3);
        pin_in = 16'h1234; tick();
        check("R11", "snapshot held", host_rdata, 16'hA5C3);
        repeat (3) tick();
        check("R2", "drdy held until read", drdy, 1);
        strobe_rd();
        check("R2", "drdy cleared by read", drdy, 0);
        measure(s, w);
        check("R4", "level settle", s, 3);
        check("R7", "ack held while request held", w, 40);
        req_pin = 0;
        tick(); tick();
        check("R7", "ack still on two cycles after release", ack_on(), 1);
        tick();
        check("R7", "ack off three cycles after release", ack_on(), 0);
        repeat (4) tick();
        check("R7", "no drdy without new request", drdy, 0);
        cfg_dblbuf = 0; #1;
        check("R11", "live pins unbuffered", host_rdata, 16'h1234);
        pin_in = 16'h0F0F; #1;
        check("R11", "live pins follow", host_rdata, 16'h0F0F);

        // Inverted polarity, leading-edge input transfer
        cfg_port_en = 0; tick();
        cfg_inv_req = 1; cfg_inv_ack = 1; req_pin = 1; cfg_pulse = 1;
        cfg_dly_sel = 2; cfg_dly_stretch = 1;
        repeat (3) tick();
        check("R8", "inverted ack idles high", ack_pin, 1);
        cfg_port_en = 1; tick();
        req_pin = 0;
        wait_drdy(c);
        check("R8", "active-low request accepted", c, 3);
        req_pin = 1;
        strobe_rd();
        measure(s, w);
        check("R8", "inverted settle", s, 2);
        check("R6", "inverted stretched width", w, exp_width(2, 1));

        // Local reset and re-arm
        cfg_port_en = 0; tick();
        cfg_inv_req = 0; cfg_inv_ack = 0; req_pin = 0;
        repeat (3) tick();
        cfg_write = 1; cfg_port_en = 1; tick();
        check("R3", "armed again", drdy, 1);
        lreset = 1; tick(); lreset = 0;
        check("R9", "drdy cleared by local reset", drdy, 0);
        check("R9", "ack inactive after local reset", ack_pin, 0);
        repeat (3) tick();
        check("R9", "no self re-arm", drdy, 0);
        cfg_write = 0; tick();
        cfg_write = 1; tick(); tick();
        check("R9", "re-armed after write toggle", drdy, 1);

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule